// File: doc/BRIEF.md
# Duplicated-Copy Multiport Register File

This block is a shared physical register file for a four-context processor core. Integer and floating-point values live in the same storage. Each of the four contexts owns 32 integer and 32 floating-point architected slots, which gives 256 architected entries. Another 256 entries hold renamed results. That makes 512 entries of 64 bits each.

The core needs sixteen reads and eight writes in each cycle. No single array carries all twenty-four ports. Instead the storage is held twice, and each copy has eight read and eight write ports. Every write is broadcast to both copies in the same cycle, so their contents stay identical. The first copy drives read ports 0 to 7 and the second drives read ports 8 to 15.

Reads are combinational. A read of an address that is being written in the same cycle sees the old contents, and any forwarding of new values is done outside the block. When two write ports aim at one address in one cycle, the higher-numbered port wins. An internal conflict wire marks that case for coverage.

Top module: `rf_dual_copy`

## Requirements
- R1: While reset is low, and after it rises with no write yet made, every read port returns zero for every address.
- R2: Read port k returns, in the same cycle and through combinational logic, the entry selected by its address field `rd_addr[9k+8:9k]`, on `rd_data[64k+63:64k]`.
- R3: When write port p has `wr_en[p]` high at a rising clock edge, `wr_data[64p+63:64p]` is stored at `wr_addr[9p+8:9p]`. From the following cycle on, every read port returns that value for that address.
- R4: Each write updates both copies. Read ports k and k+8 return identical data whenever they present the same address.
- R5: A read of an address in the same cycle as a write to it returns the value stored before that clock edge.
- R6: All eight write ports can commit to eight distinct addresses in the same cycle.
- R7: When several enabled write ports carry the same address in one cycle, only the highest-numbered of them is stored.
- R8: A write port with its enable low changes no entry, whatever address and data it presents.
- R9: The full address range 0 to 511 is usable, including the boundary entries 0 and 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears all entries |
| rd_addr | input | 144 | Sixteen 9-bit read addresses, port k at bits 9k+8:9k |
| rd_data | output | 1024 | Sixteen 64-bit read results, port k at bits 64k+63:64k |
| wr_en | input | 8 | Write enable, one bit per write port |
| wr_addr | input | 72 | Eight 9-bit write addresses, port p at bits 9p+8:9p |
| wr_data | input | 512 | Eight 64-bit write values, port p at bits 64p+63:64p |

## Verification
Single-port writes, with the value read back on all sixteen ports, show whether the value reached both copies and whether the read ports are wired to the right halves. Eight simultaneous writes to distinct addresses reveal lost or cross-wired write lanes. Same-address bursts, using all ports and also a sparse pair, show which port has priority. Reads of an address in the cycle it is written tell old-value reads apart from accidental forwarding. Disabled writes that carry live data, writes to addresses 0 and 511, and a long run of random traffic with occasional collisions cover the rest, with the read ports compared against a behavioural model on every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_WIDTH    = 64;
  localparam int RF_DEPTH    = 512;
  localparam int RF_RD_PORTS = 16;
  localparam int RF_WR_PORTS = 8;
  localparam int RF_COPIES   = 2;

  // Layout of the architected region: context, class (0 int, 1 fp), index.
  localparam int RF_CONTEXTS   = 4;
  localparam int RF_ARCH_REGS  = 32;

  function automatic int unsigned rf_arch_slot(input int unsigned ctx,
                                               input bit is_fp,
                                               input int unsigned idx);
    return ctx * (2 * RF_ARCH_REGS) + (is_fp ? RF_ARCH_REGS : 0) + idx;
  endfunction

  function automatic int unsigned rf_copy_of_port(input int unsigned rd_port,
                                                  input int unsigned per_copy);
    return rd_port / per_copy;
  endfunction
endpackage

// File: rtl/rf_wr_resolve.sv
module rf_wr_resolve #(
  parameter int NWR = 8,
  parameter int AW  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  output logic [NWR-1:0]    eff_en,
  output logic              conflict
);
  logic [NWR-1:0] shadowed;

  // True when some higher-numbered enabled port carries the same address.
  function automatic logic higher_hit(input logic [NWR-1:0] en,
                                      input logic [NWR*AW-1:0] addr,
                                      input int p);
    logic hit;
    hit = 1'b0;
    for (int q = p + 1; q < NWR; q++)
      if (en[q] && addr[q*AW +: AW] == addr[p*AW +: AW]) hit = 1'b1;
    return hit;
  endfunction

  always_comb begin
    for (int p = 0; p < NWR; p++) begin
      shadowed[p] = wr_en[p] && higher_hit(wr_en, wr_addr, p);
      eff_en[p]   = wr_en[p] && !shadowed[p];
    end
    conflict = |shadowed;
  end

  // After resolution no two surviving writes may share an address.
  genvar i, j;
  generate
    for (i = 0; i < NWR; i++) begin : g_pi
      for (j = i + 1; j < NWR; j++) begin : g_pj
        a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
          !(eff_en[i] && eff_en[j] && wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]));
      end
      // The top enabled port for an address is never suppressed (R7).
      if (i == NWR - 1) begin : g_top
        a_r7_top_port_kept: assert property (@(posedge clk) disable iff (!rst_n)
          wr_en[i] |-> eff_en[i]);
      end
    end
  endgenerate

  c_r7_write_conflict: cover property (@(posedge clk) disable iff (!rst_n) conflict);
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int W     = 64,
  parameter int DEPTH = 512,
  parameter int NRD   = 8,
  parameter int NWR   = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWR-1:0]    eff_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*W-1:0]  wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*W-1:0]  rd_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wa  [NWR];
  logic [W-1:0]  wd  [NWR];

  genvar p, r;
  generate
    for (p = 0; p < NWR; p++) begin : g_wsplit
      assign wa[p] = wr_addr[p*AW +: AW];
      assign wd[p] = wr_data[p*W +: W];
    end
  endgenerate

  // Surviving writes carry distinct addresses, so port order does not matter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int q = 0; q < NWR; q++)
        if (eff_en[q]) mem[wa[q]] <= wd[q];
    end
  end

  generate
    for (r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r*W +: W] = mem[rd_addr[r*AW +: AW]];
    end
    for (p = 0; p < NWR; p++) begin : g_chk
      a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        eff_en[p] |=> mem[$past(wa[p])] == $past(wd[p]));
    end
  endgenerate
endmodule

// File: rtl/rf_dual_copy.sv
module rf_dual_copy
  import rf_pkg::*;
#(
  parameter int W      = RF_WIDTH,
  parameter int DEPTH  = RF_DEPTH,
  parameter int NRD    = RF_RD_PORTS,
  parameter int NWR    = RF_WR_PORTS,
  parameter int COPIES = RF_COPIES,
  localparam int AW    = $clog2(DEPTH),
  localparam int PER   = NRD / COPIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*W-1:0]  rd_data,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*W-1:0]  wr_data
);
  logic [NWR-1:0] eff_en;
  logic           wr_conflict;

  rf_wr_resolve #(.NWR(NWR), .AW(AW)) u_resolve (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .eff_en  (eff_en),
    .conflict(wr_conflict)
  );

  // Each copy sees the full write broadcast and serves one slice of reads.
  genvar c, k;
  generate
    for (c = 0; c < COPIES; c++) begin : g_copy
      rf_bank #(.W(W), .DEPTH(DEPTH), .NRD(PER), .NWR(NWR)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .eff_en (eff_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr[c*PER*AW +: PER*AW]),
        .rd_data(rd_data[c*PER*W +: PER*W])
      );
    end
    for (k = 0; k < PER; k++) begin : g_pair
      a_r4_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[k*AW +: AW] == rd_addr[(k+PER)*AW +: AW])
          |-> (rd_data[k*W +: W] == rd_data[(k+PER)*W +: W]));
    end
  endgenerate

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(|wr_en) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

// File: tb/rf_dual_copy_tb.sv
module rf_dual_copy_tb;
  localparam int W = 64, DEPTH = 512, NRD = 16, NWR = 8, AW = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NRD*AW-1:0] rd_addr;
  logic [NRD*W-1:0]  rd_data;
  logic [NWR-1:0]    wr_en;
  logic [NWR*AW-1:0] wr_addr;
  logic [NWR*W-1:0]  wr_data;

  logic [AW-1:0] ra [NRD];
  logic [AW-1:0] wa [NWR];
  logic [W-1:0]  wd [NWR];
  logic [W-1:0]  model [DEPTH];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  rf_dual_copy u_dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NRD; i++) rd_addr[i*AW +: AW] = ra[i];
    for (int p = 0; p < NWR; p++) begin
      wr_addr[p*AW +: AW] = wa[p];
      wr_data[p*W +: W]   = wd[p];
    end
  end

  task automatic compare(input string tag);
    for (int i = 0; i < NRD; i++) begin
      vectors++;
      if (rd_data[i*W +: W] !== model[ra[i]]) begin
        fails++;
        $display("FAIL %s port %0d addr %0d: got %h expected %h",
                 tag, i, ra[i], rd_data[i*W +: W], model[ra[i]]);
      end
    end
  endtask

  // Inputs already driven; check reads (old contents), then clock, then update model.
  task automatic step(input string tag);
    #1;
    compare(tag);
    @(posedge clk);
    if (rst_n) begin
      for (int p = 0; p < NWR; p++)
        if (wr_en[p]) model[wa[p]] = wd[p];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = '0;
    for (int p = 0; p < NWR; p++) begin wa[p] = '0; wd[p] = '0; end
  endtask

  task automatic read_all(input logic [AW-1:0] a);
    for (int i = 0; i < NRD; i++) ra[i] = a;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < DEPTH; e++) model[e] = '0;
    idle();
    for (int i = 0; i < NRD; i++) ra[i] = AW'(i * 37);
    @(negedge clk);
    // R1: contents read zero under reset, even with a write presented
    wr_en = 8'h01; wa[0] = 9'd5; wd[0] = 64'hdead;
    step("R1");
    idle();
    step("R1");
    rst_n = 1'b1;
    for (int i = 0; i < NRD; i++) ra[i] = AW'(DEPTH - 1 - i * 31);
    step("R1");

    // R3 / R2: single write on port 0, visible next cycle on all ports
    wr_en = 8'h01; wa[0] = 9'd10; wd[0] = 64'h0123_4567_89ab_cdef;
    read_all(9'd10);
    step("R5");
    idle();
    step("R3");
    // R2: spread reads over distinct addresses
    for (int i = 0; i < NRD; i++) ra[i] = (i == 3) ? 9'd10 : AW'(i);
    step("R2");

    // R6 / R4: eight distinct writes, ports k and k+8 read the same address
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = 1'b1; wa[p] = AW'(100 + p * 3); wd[p] = {32'hA5A5_0000 + p, 32'(p * 17)};
    end
    step("R6");
    idle();
    for (int i = 0; i < NRD; i++) ra[i] = AW'(100 + (i % 8) * 3);
    step("R4");

    // R5: write and read the same address in one cycle returns old data
    wr_en = 8'h10; wa[4] = 9'd100; wd[4] = 64'hffff_0000_ffff_0000;
    read_all(9'd100);
    step("R5");
    idle();
    step("R3");

    // R7: all ports hit one address, port 7 wins
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = 1'b1; wa[p] = 9'd200; wd[p] = 64'h7700 + p;
    end
    read_all(9'd200);
    step("R7");
    idle();
    step("R7");
    // R7: sparse conflict, ports 2 and 5, port 5 wins; port 0 elsewhere
    wr_en = 8'b0010_0101;
    wa[0] = 9'd201; wd[0] = 64'h1;
    wa[2] = 9'd202; wd[2] = 64'h2222;
    wa[5] = 9'd202; wd[5] = 64'h5555;
    step("R7");
    idle();
    for (int i = 0; i < NRD; i++) ra[i] = (i % 2) ? 9'd202 : 9'd201;
    step("R7");

    // R8: disabled ports carrying live data change nothing
    wr_en = '0;
    for (int p = 0; p < NWR; p++) begin wa[p] = 9'd202; wd[p] = 64'hbad0 + p; end
    step("R8");
    idle();
    read_all(9'd202);
    step("R8");

    // R9: boundary entries 0 and 511
    wr_en = 8'b1000_0001; wa[0] = 9'd0; wd[0] = 64'h0f0f; wa[7] = 9'd511; wd[7] = 64'hf0f0_f0f0_f0f0_f0f0;
    step("R9");
    idle();
    for (int i = 0; i < NRD; i++) ra[i] = (i < 8) ? 9'd0 : 9'd511;
    step("R9");
    for (int i = 0; i < NRD; i++) ra[i] = (i < 8) ? 9'd511 : 9'd0;
    step("R9");

    // R2: random traffic with occasional collisions
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NWR; p++) begin
        wr_en[p] = ($urandom % 3) != 0;
        wa[p]    = ($urandom % 4 == 0) ? AW'($urandom % 16) : AW'($urandom);
        wd[p]    = {$urandom, $urandom};
      end
      for (int i = 0; i < NRD; i++)
        ra[i] = ($urandom % 2) ? AW'($urandom % 16) : AW'($urandom);
      step("R2");
    end
    idle();
    step("R2");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule